// File: doc/BRIEF.md
# Slope-Compensation Ramp Generator

This block produces a digital sawtooth for the reference input of a 12-bit comparator DAC. Peak-current-mode power converters use it to add slope compensation. A 16-bit accumulator starts at full scale (65535) and falls by a programmable step on every enabled clock. When it reaches zero it reloads full scale and the next ramp begins. The DAC code is the upper 12 bits of the accumulator, so the lower 4 bits act as a fractional prescale. This lets small steps give long, smooth ramps. For example, a step of 655 at a 100 MHz clock gives a ramp period of roughly 1 us.

A one-cycle wrap pulse marks each natural reload, so the rest of the converter control can align to the ramp. An external restart strobe forces the ramp back to full scale at any time, for example at the start of a switching period. A new step value is only taken at a reload, so the slope of a ramp that is already running never changes. This block drives only the ramp reference. Any second, static comparator reference lives outside it.

Top module: `slope_ramp_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator loads 65535 and `wrap` goes low, so after that edge `dac_code` is 4095. `step_in` is latched as the active step.
- R2: At a rising edge with `en` high, `restart` low and the accumulator non-zero, the accumulator decreases by the active step whenever the active step is smaller than the accumulator.
- R3: At such an edge, a non-zero active step that is greater than or equal to the accumulator makes the accumulator zero. It never wraps below zero.
- R4: At a rising edge with `en` high, `restart` low and the accumulator at zero, the accumulator reloads 65535. `wrap` is high for exactly the one cycle that follows that edge.
- R5: When `restart` is high at a rising edge (and `RESTART_EN` is 1), the accumulator reloads 65535 whatever its value and whatever `en` is. The restart takes priority over the decrement and `step_in` is latched. `wrap` stays low.
- R6: At a rising edge with `en` low and `restart` low, the accumulator keeps its value and `wrap` is low.
- R7: `step_in` becomes the active step only at reset, at a reload from zero, or at a restart. A change at any other time does not alter the current ramp's slope.
- R8: While the active step is zero, the accumulator stays at full scale and `wrap` never pulses.
- R9: `dac_code` equals bits [15:4] of the accumulator, which is the accumulator divided by 16, rounded down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Ramp advance enable |
| step_in | input | 16 | Decrement per clock, latched at reset, reload or restart |
| restart | input | 1 | Strobe forcing an immediate reload to full scale |
| dac_code | output | 12 | Upper accumulator bits for the comparator DAC |
| wrap | output | 1 | One-cycle pulse after a natural reload from zero |

## Verification
Every result is registered. The effect of a stimulus present at one rising edge shows on `dac_code` and `wrap` right after that edge, with no further latency, and the wrap pulse lasts one cycle. The bench changes inputs on falling edges. It counts the exact number of rising edges that pass with `en` high, then samples the outputs on the next falling edge, so each expected value matches a known number of steps from full scale. Hold, restart and step-change cases are checked one edge after their stimulus. They are checked again after further edges, to show that no later change appears.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_RELOAD = 2'd1,
      OP_SUB    = 2'd2,
      OP_CLEAR  = 2'd3
   } ramp_op_e;

endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
   import ramp_pkg::*;
(
   input  logic     rst,
   input  logic     en,
   input  logic     restart_eff,
   input  logic     acc_zero,
   input  logic     step_zero,
   input  logic     step_covers,
   output ramp_op_e op,
   output logic     wrap_set,
   output logic     take_step
);

   always_comb begin
      op        = OP_HOLD;
      wrap_set  = 1'b0;
      take_step = 1'b0;
      if (rst) begin
         op        = OP_RELOAD;
         take_step = 1'b1;
      end else if (restart_eff) begin
         op        = OP_RELOAD;
         take_step = 1'b1;
      end else if (en) begin
         if (acc_zero) begin
            op        = OP_RELOAD;
            wrap_set  = 1'b1;
            take_step = 1'b1;
         end else if (step_zero) begin
            op = OP_HOLD;
         end else if (step_covers) begin
            op = OP_CLEAR;
         end else begin
            op = OP_SUB;
         end
      end
   end

endmodule

// File: rtl/ramp_step_reg.sv
module ramp_step_reg #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             take,
   input  logic [ACC_W-1:0] step_in,
   output logic [ACC_W-1:0] step_q
);

   always_ff @(posedge clk) begin
      if (take) step_q <= step_in;
   end

endmodule

// File: rtl/ramp_accum.sv
module ramp_accum
   import ramp_pkg::*;
#(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  ramp_op_e         op,
   input  logic             wrap_set,
   input  logic [ACC_W-1:0] step,
   output logic [ACC_W-1:0] acc_q,
   output logic             wrap_q,
   output logic             acc_zero,
   output logic             step_zero,
   output logic             step_covers
);

   localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

   logic [ACC_W-1:0] acc_d;

   assign acc_zero    = (acc_q == '0);
   assign step_zero   = (step == '0);
   assign step_covers = (step >= acc_q);

   always_comb begin
      unique case (op)
         OP_RELOAD: acc_d = FULL;
         OP_SUB:    acc_d = acc_q - step;
         OP_CLEAR:  acc_d = '0;
         default:   acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      acc_q  <= acc_d;
      wrap_q <= wrap_set;
   end

endmodule

// File: rtl/ramp_dac_map.sv
module ramp_dac_map #(
   parameter int ACC_W = 16,
   parameter int DAC_W = 12
) (
   input  logic [ACC_W-1:0] acc,
   output logic [DAC_W-1:0] code
);

   localparam int FRAC_W = ACC_W - DAC_W;

   generate
      if (FRAC_W == 0) begin : g_direct
         assign code = acc;
      end else begin : g_slice
         logic [FRAC_W-1:0] unused_frac;
         assign unused_frac = acc[FRAC_W-1:0];
         assign code        = acc[ACC_W-1:FRAC_W];
      end
   endgenerate

endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen
   import ramp_pkg::*;
#(
   parameter int ACC_W      = 16,
   parameter int DAC_W      = 12,
   parameter bit RESTART_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [ACC_W-1:0] step_in,
   input  logic             restart,
   output logic [DAC_W-1:0] dac_code,
   output logic             wrap
);

   generate
      if (DAC_W > ACC_W) begin : g_bad_width
         $error("slope_ramp_gen: DAC_W must not exceed ACC_W");
      end
      if (DAC_W < 1 || ACC_W < 2) begin : g_bad_size
         $error("slope_ramp_gen: widths too small");
      end
   endgenerate

   ramp_op_e         op;
   logic             wrap_set, take_step, restart_eff;
   logic             acc_zero, step_zero, step_covers;
   logic [ACC_W-1:0] step_q, acc_q;

   generate
      if (RESTART_EN) begin : g_restart
         assign restart_eff = restart;
      end else begin : g_no_restart
         logic unused_restart;
         assign unused_restart = restart;
         assign restart_eff    = 1'b0;
      end
   endgenerate

   ramp_ctrl u_ctrl (
      .rst         (rst),
      .en          (en),
      .restart_eff (restart_eff),
      .acc_zero    (acc_zero),
      .step_zero   (step_zero),
      .step_covers (step_covers),
      .op          (op),
      .wrap_set    (wrap_set),
      .take_step   (take_step)
   );

   ramp_step_reg #(.ACC_W(ACC_W)) u_step (
      .clk     (clk),
      .take    (take_step),
      .step_in (step_in),
      .step_q  (step_q)
   );

   ramp_accum #(.ACC_W(ACC_W)) u_acc (
      .clk         (clk),
      .op          (op),
      .wrap_set    (wrap_set),
      .step        (step_q),
      .acc_q       (acc_q),
      .wrap_q      (wrap),
      .acc_zero    (acc_zero),
      .step_zero   (step_zero),
      .step_covers (step_covers)
   );

   ramp_dac_map #(.ACC_W(ACC_W), .DAC_W(DAC_W)) u_map (
      .acc  (acc_q),
      .code (dac_code)
   );

endmodule

// File: rtl/slope_ramp_gen_chk.sv
module slope_ramp_gen_chk #(
   parameter int ACC_W      = 16,
   parameter int DAC_W      = 12,
   parameter bit RESTART_EN = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             restart,
   input logic [DAC_W-1:0] dac_code,
   input logic             wrap,
   input logic [ACC_W-1:0] acc
);

   logic rs;
   assign rs = RESTART_EN && restart;

   // R1
   a_r1_reset_full: assert property (@(posedge clk)
      rst |=> (acc == '1) && !wrap);

   // R2, R3
   a_r2_never_rises: assert property (@(posedge clk) disable iff (rst)
      (!rs && en && acc != '0) |=> acc <= $past(acc));

   // R4
   a_r4_reload_from_zero: assert property (@(posedge clk) disable iff (rst)
      (!rs && en && acc == '0) |=> (acc == '1) && wrap);

   // R4
   a_r4_wrap_at_full: assert property (@(posedge clk) disable iff (rst)
      wrap |-> (dac_code == '1));

   // R5
   a_r5_restart_reload: assert property (@(posedge clk) disable iff (rst)
      rs |=> (acc == '1) && !wrap);

   // R6
   a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
      (!rs && !en) |=> $stable(acc) && !wrap);

endmodule

bind slope_ramp_gen slope_ramp_gen_chk #(
   .ACC_W(ACC_W), .DAC_W(DAC_W), .RESTART_EN(RESTART_EN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .restart  (restart),
   .dac_code (dac_code),
   .wrap     (wrap),
   .acc      (acc_q)
);

// File: tb/slope_ramp_gen_bench.sv
module slope_ramp_gen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [15:0] step_in = 16'd0;
   logic        restart = 1'b0;
   logic [11:0] dac_code;
   logic        wrap;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   slope_ramp_gen u_slope_ramp_gen (
      .clk(clk), .rst(rst), .en(en), .step_in(step_in),
      .restart(restart), .dac_code(dac_code), .wrap(wrap)
   );

   typedef struct packed {
      logic [15:0] step;
      logic [7:0]  cycles;
      logic [11:0] exp_dac;
      logic        exp_wrap;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{16'd655,   8'd10,  12'd3686, 1'b0},
      '{16'd4096,  8'd15,  12'd255,  1'b0},
      '{16'd4096,  8'd16,  12'd0,    1'b0},
      '{16'd4096,  8'd17,  12'd4095, 1'b1},
      '{16'd1,     8'd16,  12'd4094, 1'b0},
      '{16'd0,     8'd50,  12'd4095, 1'b0},
      '{16'd65535, 8'd1,   12'd0,    1'b0},
      '{16'd65535, 8'd2,   12'd4095, 1'b1},
      '{16'd16384, 8'd3,   12'd1023, 1'b0},
      '{16'd16384, 8'd5,   12'd4095, 1'b1},
      '{16'd655,   8'd100, 12'd2,    1'b0},
      '{16'd655,   8'd101, 12'd0,    1'b0},
      '{16'd655,   8'd102, 12'd4095, 1'b1}
   };

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset(input logic [15:0] s);
      @(negedge clk);
      rst = 1'b1; en = 1'b0; restart = 1'b0; step_in = s;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic run(input int n);
      en = 1'b1;
      repeat (n) @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      do_reset(16'd655);
      check("R1 reset dac", int'(dac_code), 4095);
      check("R1 reset wrap", int'(wrap), 0);

      // R2 R3 R4 R8 R9: table of ramps from full scale
      for (int i = 0; i < NV; i++) begin
         do_reset(TBL[i].step);
         run(int'(TBL[i].cycles));
         check($sformatf("R2/R3/R9 row %0d dac", i), int'(dac_code), int'(TBL[i].exp_dac));
         check($sformatf("R4/R8 row %0d wrap", i), int'(wrap), int'(TBL[i].exp_wrap));
      end

      // R4: wrap lasts one cycle
      do_reset(16'd65535);
      run(2);
      check("R4 wrap high", int'(wrap), 1);
      run(1);
      check("R4 wrap one cycle", int'(wrap), 0);
      check("R4 ramp restarted", int'(dac_code), 0);

      // R6: enable low holds
      do_reset(16'd1000);
      run(5);
      check("R6 before hold", int'(dac_code), 3783);
      repeat (10) @(negedge clk);
      check("R6 held dac", int'(dac_code), 3783);
      check("R6 held wrap", int'(wrap), 0);

      // R7: step change mid-ramp waits for reload
      do_reset(16'd16384);
      run(1);
      check("R7 first step", int'(dac_code), 3071);
      step_in = 16'd1;
      run(1);
      check("R7 old slope kept", int'(dac_code), 2047);
      run(3);
      check("R7 reload wrap", int'(wrap), 1);
      run(17);
      check("R7 new slope", int'(dac_code), 4094);

      // R5: restart with enable low, mid-ramp
      do_reset(16'd4096);
      run(5);
      check("R5 mid ramp", int'(dac_code), 2815);
      step_in = 16'd8192;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      check("R5 restart full", int'(dac_code), 4095);
      check("R5 restart no wrap", int'(wrap), 0);
      run(1);
      check("R5 step latched", int'(dac_code), 3583);

      // R5: restart beats the reload at zero
      do_reset(16'd65535);
      run(1);
      check("R5 at zero", int'(dac_code), 0);
      restart = 1'b1; en = 1'b1;
      @(negedge clk);
      restart = 1'b0; en = 1'b0;
      check("R5 priority dac", int'(dac_code), 4095);
      check("R5 priority no wrap", int'(wrap), 0);

      // R8: zero step arriving through a reload keeps full scale
      do_reset(16'd65535);
      step_in = 16'd0;
      run(2);
      check("R8 reload wrap", int'(wrap), 1);
      run(20);
      check("R8 held full", int'(dac_code), 4095);
      check("R8 no wrap", int'(wrap), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule